// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a small programmable array device: a bank of eight macrocells, each fed by one sum-of-products term from the array. A two-bit global mode selects how the whole bank is wired. Per-cell configuration bits set output polarity, whether the pin is an input or an output, and whether the pin is driven totem-pole or open-drain. The bank drives pin values, pin enables, open-drain flags and the feedback lines that return into the array.

Two shared pins change their role with the global mode. In registered mode they are the register clock and an active-low output enable. In complex mode they become plain inputs, and their values are carried into the array on the feedback lines of the two outermost cells. Cells are numbered 0 to 7. Cells 0 and 7 are the outermost and cells 3 and 4 are the innermost. The configuration word is 26 bits: the two global bits plus three bits per cell.

Top module: `mc_bank`

## Requirements
- R1: The global mode is {cfgSyn,cfgAc0}: 2'b10 is simple, 2'b11 is complex and 2'b01 is registered. 2'b00 is reserved. In the reserved mode every padOe bit, padOut bit and fbOut bit is 0.
- R2: In simple and complex modes, padOut[i] equals sumTerm[i] XOR cfgXor[i]. In registered mode, the register captures sumTerm[i] XOR cfgXor[i].
- R3: In simple mode, the enable of cell i is NOT cfgAc1[i]. Cells 3 and 4 are always enabled, whatever their cfgAc1 bit.
- R4: In simple mode, feedback comes from the adjacent pin. fbOut[i] = padIn[i+1] for i = 0..2, and fbOut[i] = padIn[i-1] for i = 5..7. fbOut[3] and fbOut[4] are 0.
- R5: In complex mode, the enable of cell i is oeTerm[i] AND NOT cfgAc1[i].
- R6: In complex mode, fbOut[0] equals sharedClkPin and fbOut[7] equals sharedOePin. For i = 1..6, fbOut[i] equals padIn[i].
- R7: In registered mode, each cell's register loads on the rising edge of sharedClkPin. padOut holds that registered value between edges. An asynchronous low rstN clears all registers to 0.
- R8: In registered mode, the enable of cell i is NOT sharedOePin AND NOT cfgAc1[i]. fbOut[i] is the inverted register value when cfgAc1[i] = 0, and padIn[i] when cfgAc1[i] = 1.
- R9: padOd[i] equals cfgAc2[i]. With cfgAc2[i] = 1 (open-drain), padOe[i] is asserted only when the cell is enabled and padOut[i] is 0. With cfgAc2[i] = 0 (totem-pole), padOe[i] equals the cell enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of the cell registers |
| sharedClkPin | input | 1 | Shared pin: register clock in registered mode, plain input in complex mode |
| sharedOePin | input | 1 | Shared pin: active-low output enable in registered mode, plain input in complex mode |
| cfgSyn | input | 1 | Global mode bit, upper |
| cfgAc0 | input | 1 | Global mode bit, lower |
| cfgXor | input | 8 | Per-cell polarity bit |
| cfgAc1 | input | 8 | Per-cell input select (1 = dedicated input) |
| cfgAc2 | input | 8 | Per-cell drive select (1 = open-drain) |
| sumTerm | input | 8 | Sum-of-products term for each cell |
| oeTerm | input | 8 | Enable product term for each cell (complex mode) |
| padIn | input | 8 | Value seen on each cell's pin |
| padOut | output | 8 | Output data value per pin |
| padOe | output | 8 | Output enable per pin |
| padOd | output | 8 | Open-drain flag per pin |
| fbOut | output | 8 | Feedback lines into the array |

## Verification
The bench targets the places where the mode changes the routing. Each of these mistakes shows up at the ports. If the adjacent-pin feedback were mis-indexed, simple mode would return a pin's own value or a value shifted the wrong way. If the inner cells honoured their input bit, they would release the pin. If the shared-pin feedback were missing in complex mode, fbOut[0] and fbOut[7] would show pad values instead of the shared pins. The registered path is checked for a value that holds between clock edges and for the inverted feedback; a transparent path would follow sumTerm straight away. Open-drain cells are driven with both data levels, so a cell that drove a high would be caught.

// File: rtl/mc_bank_pkg.sv
package mc_bank_pkg;

  // Global mode, encoded as {syn, ac0}
  typedef enum logic [1:0] {
    MODE_RSVD    = 2'b00,
    MODE_REG     = 2'b01,
    MODE_SIMPLE  = 2'b10,
    MODE_COMPLEX = 2'b11
  } mcMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic simpleEn;
    logic complexEn;
    logic regEn;
    logic regOeOn;
  } mcStrobe_t;

endpackage

// File: rtl/mc_bank_ctrl.sv
module mc_bank_ctrl
  import mc_bank_pkg::*;
(
  input  logic      cfgSyn,
  input  logic      cfgAc0,
  input  logic      sharedOePin,
  output mcStrobe_t strobe
);

  mcMode_e mode;
  assign mode = mcMode_e'({cfgSyn, cfgAc0});

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_SIMPLE:  strobe.simpleEn  = 1'b1;
      MODE_COMPLEX: strobe.complexEn = 1'b1;
      MODE_REG: begin
        strobe.regEn   = 1'b1;
        strobe.regOeOn = ~sharedOePin;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/mc_bank_dp.sv
module mc_bank_dp
  import mc_bank_pkg::*;
#(
  parameter int NumCells = 8
) (
  input  logic                rstN,
  input  logic                sharedClkPin,
  input  logic                sharedOePin,
  input  mcStrobe_t           strobe,
  input  logic [NumCells-1:0] cfgXor,
  input  logic [NumCells-1:0] cfgAc1,
  input  logic [NumCells-1:0] cfgAc2,
  input  logic [NumCells-1:0] sumTerm,
  input  logic [NumCells-1:0] oeTerm,
  input  logic [NumCells-1:0] padIn,
  output logic [NumCells-1:0] padOut,
  output logic [NumCells-1:0] padOe,
  output logic [NumCells-1:0] padOd,
  output logic [NumCells-1:0] fbOut
);

  localparam int InnerLo = NumCells / 2 - 1;
  localparam int InnerHi = NumCells / 2;

  logic [NumCells-1:0] polData;
  logic [NumCells-1:0] regQ;

  assign polData = sumTerm ^ cfgXor;
  assign padOd   = cfgAc2;

  always_ff @(posedge sharedClkPin or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= polData;
  end

  for (genvar i = 0; i < NumCells; i++) begin : g_cell
    localparam bit IsInner = (i == InnerLo) || (i == InnerHi);
    logic simpleFbSrc;
    logic complexFbSrc;
    logic cellData;
    logic cellEn;
    logic cellFb;

    // simple mode: feedback taken from the neighbour nearer the centre
    if (i < InnerLo) begin : g_sfb_up
      assign simpleFbSrc = padIn[i+1];
    end else if (i > InnerHi) begin : g_sfb_dn
      assign simpleFbSrc = padIn[i-1];
    end else begin : g_sfb_none
      assign simpleFbSrc = 1'b0;
    end

    // complex mode: outermost cells carry the shared pins
    if (i == 0) begin : g_cfb_clk
      assign complexFbSrc = sharedClkPin;
    end else if (i == NumCells - 1) begin : g_cfb_oe
      assign complexFbSrc = sharedOePin;
    end else begin : g_cfb_own
      assign complexFbSrc = padIn[i];
    end

    always_comb begin
      cellData = 1'b0;
      cellEn   = 1'b0;
      cellFb   = 1'b0;
      if (strobe.regEn) begin
        cellData = regQ[i];
        cellEn   = strobe.regOeOn & ~cfgAc1[i];
        cellFb   = cfgAc1[i] ? padIn[i] : ~regQ[i];
      end else if (strobe.complexEn) begin
        cellData = polData[i];
        cellEn   = oeTerm[i] & ~cfgAc1[i];
        cellFb   = complexFbSrc;
      end else if (strobe.simpleEn) begin
        cellData = polData[i];
        cellEn   = IsInner ? 1'b1 : ~cfgAc1[i];
        cellFb   = simpleFbSrc;
      end
    end

    assign padOut[i] = cellData;
    assign padOe[i]  = cellEn & (~cfgAc2[i] | ~cellData);
    assign fbOut[i]  = cellFb;
  end

endmodule

// File: rtl/mc_bank.sv
module mc_bank
  import mc_bank_pkg::*;
#(
  parameter int NumCells = 8
) (
  input  logic                rstN,
  input  logic                sharedClkPin,
  input  logic                sharedOePin,
  input  logic                cfgSyn,
  input  logic                cfgAc0,
  input  logic [NumCells-1:0] cfgXor,
  input  logic [NumCells-1:0] cfgAc1,
  input  logic [NumCells-1:0] cfgAc2,
  input  logic [NumCells-1:0] sumTerm,
  input  logic [NumCells-1:0] oeTerm,
  input  logic [NumCells-1:0] padIn,
  output logic [NumCells-1:0] padOut,
  output logic [NumCells-1:0] padOe,
  output logic [NumCells-1:0] padOd,
  output logic [NumCells-1:0] fbOut
);

  mcStrobe_t strobe;

  mc_bank_ctrl ctrl_i (
    .cfgSyn      (cfgSyn),
    .cfgAc0      (cfgAc0),
    .sharedOePin (sharedOePin),
    .strobe      (strobe)
  );

  mc_bank_dp #(.NumCells(NumCells)) dp_i (
    .rstN         (rstN),
    .sharedClkPin (sharedClkPin),
    .sharedOePin  (sharedOePin),
    .strobe       (strobe),
    .cfgXor       (cfgXor),
    .cfgAc1       (cfgAc1),
    .cfgAc2       (cfgAc2),
    .sumTerm      (sumTerm),
    .oeTerm       (oeTerm),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .padOd        (padOd),
    .fbOut        (fbOut)
  );

endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk #(
  parameter int NumCells = 8
) (
  input logic                rstN,
  input logic                sharedClkPin,
  input logic                sharedOePin,
  input logic                cfgSyn,
  input logic                cfgAc0,
  input logic [NumCells-1:0] cfgXor,
  input logic [NumCells-1:0] sumTerm,
  input logic [NumCells-1:0] padOut,
  input logic [NumCells-1:0] padOe,
  input logic [NumCells-1:0] padOd,
  input logic [NumCells-1:0] fbOut
);

  localparam int InnerLo = NumCells / 2 - 1;
  localparam int InnerHi = NumCells / 2;

  logic [1:0] modeBits;
  logic       pastValid;

  assign modeBits = {cfgSyn, cfgAc0};

  always_ff @(posedge sharedClkPin or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_RSVD_QUIET: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    (modeBits == 2'b00) |-> (padOe == '0 && fbOut == '0)); // R1

  AST_SIMPLE_INNER_NOFB: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    (modeBits == 2'b10) |-> (fbOut[InnerLo] == 1'b0 && fbOut[InnerHi] == 1'b0)); // R4

  AST_COMPLEX_SHARED_FB: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    (modeBits == 2'b11) |-> (fbOut[0] == sharedClkPin && fbOut[NumCells-1] == sharedOePin)); // R6

  AST_REG_CAPTURE: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    (pastValid && modeBits == 2'b01) |-> (padOut == $past(sumTerm ^ cfgXor))); // R7

  AST_REG_OE_OFF: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    (modeBits == 2'b01 && sharedOePin) |-> (padOe == '0)); // R8

  AST_OD_NO_DRIVE_HIGH: assert property (@(posedge sharedClkPin) disable iff (!rstN)
    ((padOe & padOd & padOut) == '0)); // R9

endmodule

bind mc_bank mc_bank_chk #(.NumCells(NumCells)) chk_i (
  .rstN         (rstN),
  .sharedClkPin (sharedClkPin),
  .sharedOePin  (sharedOePin),
  .cfgSyn       (cfgSyn),
  .cfgAc0       (cfgAc0),
  .cfgXor       (cfgXor),
  .sumTerm      (sumTerm),
  .padOut       (padOut),
  .padOe        (padOe),
  .padOd        (padOd),
  .fbOut        (fbOut)
);

// File: tb/mc_bank_tb_top.sv
module mc_bank_tb_top;

  localparam int ClkPeriod = 10;

  logic       rstN = 1'b0;
  logic       sharedClkPin = 1'b0;
  logic       sharedOePin = 1'b0;
  logic       cfgSyn = 1'b0;
  logic       cfgAc0 = 1'b1;
  logic [7:0] cfgXor = '0;
  logic [7:0] cfgAc1 = '0;
  logic [7:0] cfgAc2 = '0;
  logic [7:0] sumTerm = '0;
  logic [7:0] oeTerm = '0;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe, padOd, fbOut;

  int checks = 0;
  int errors = 0;

  always #(ClkPeriod / 2) sharedClkPin = ~sharedClkPin;

  mc_bank dut_i (
    .rstN(rstN), .sharedClkPin(sharedClkPin), .sharedOePin(sharedOePin),
    .cfgSyn(cfgSyn), .cfgAc0(cfgAc0), .cfgXor(cfgXor), .cfgAc1(cfgAc1),
    .cfgAc2(cfgAc2), .sumTerm(sumTerm), .oeTerm(oeTerm), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padOd(padOd), .fbOut(fbOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge sharedClkPin);
    #1;
  endtask

  // R7: reset clears the registers
  task automatic t_reset();
    rstN = 1'b0; cfgSyn = 1'b0; cfgAc0 = 1'b1; sumTerm = 8'hFF; sharedOePin = 1'b0;
    settle();
    check("R7 reset value", padOut, 8'h00);
    check("R8 reset feedback", fbOut, 8'hFF);
    rstN = 1'b1;
  endtask

  task automatic t_reserved();
    @(negedge sharedClkPin);
    cfgSyn = 1'b0; cfgAc0 = 1'b0; sumTerm = 8'hA7; oeTerm = 8'hFF; padIn = 8'h3C;
    #1;
    check("R1 reserved enables", padOe, 8'h00);
    check("R1 reserved feedback", fbOut, 8'h00);
    check("R1 reserved data", padOut, 8'h00);
  endtask

  task automatic t_simple();
    @(negedge sharedClkPin);
    cfgSyn = 1'b1; cfgAc0 = 1'b0; cfgXor = 8'h0F; sumTerm = 8'h3C;
    cfgAc1 = 8'h00; cfgAc2 = 8'h00; padIn = 8'hA5;
    #1;
    check("R2 simple polarity", padOut, 8'h33);
    check("R3 simple enables", padOe, 8'hFF);
    // padIn A5 = 1010_0101: fb0=in1=0 fb1=in2=1 fb2=in3=0 fb5=in4=0 fb6=in5=1 fb7=in6=0
    check("R4 simple adjacent feedback", fbOut, 8'h42);
    padIn = 8'h5A;
    #1;
    // 5A = 0101_1010: fb0=1 fb1=0 fb2=1 fb5=1 fb6=0 fb7=1
    check("R4 simple adjacent feedback 2", fbOut, 8'hA5);
    cfgAc1 = 8'hFF;
    #1;
    check("R3 simple inner always enabled", padOe, 8'h18);
    cfgAc1 = 8'h00;
  endtask

  task automatic t_complex();
    @(negedge sharedClkPin);
    cfgSyn = 1'b1; cfgAc0 = 1'b1; cfgXor = 8'hFF; sumTerm = 8'h0F;
    oeTerm = 8'h5A; cfgAc1 = 8'h00; cfgAc2 = 8'h00; padIn = 8'h66; sharedOePin = 1'b1;
    #1;
    check("R2 complex polarity", padOut, 8'hF0);
    check("R5 complex enables", padOe, 8'h5A);
    check("R6 complex feedback", fbOut, (8'h66 & 8'h7E) | {sharedOePin, 6'b0, sharedClkPin});
    cfgAc1 = 8'h02;
    sharedOePin = 1'b0;
    padIn = 8'h99;
    #1;
    check("R5 complex input cell disabled", padOe, 8'h58);
    check("R6 complex feedback 2", fbOut, (8'h99 & 8'h7E) | {sharedOePin, 6'b0, sharedClkPin});
    @(posedge sharedClkPin);
    #1;
    check("R6 complex shared clock pin high", fbOut, (8'h99 & 8'h7E) | 8'h01);
    cfgAc1 = 8'h00;
  endtask

  task automatic t_registered();
    @(negedge sharedClkPin);
    cfgSyn = 1'b0; cfgAc0 = 1'b1; sharedOePin = 1'b0; cfgAc1 = 8'h00; cfgAc2 = 8'h00;
    cfgXor = 8'hF0; sumTerm = 8'h0F;
    settle();
    check("R7 registered capture", padOut, 8'hFF);
    check("R8 registered enables", padOe, 8'hFF);
    check("R8 registered inverted feedback", fbOut, 8'h00);
    sumTerm = 8'h00;
    #1;
    check("R7 registered hold between edges", padOut, 8'hFF);
    settle();
    check("R2 registered polarity capture", padOut, 8'hF0);
    sharedOePin = 1'b1;
    #1;
    check("R8 shared enable high disables", padOe, 8'h00);
    sharedOePin = 1'b0; cfgAc1 = 8'h81; padIn = 8'h81;
    #1;
    check("R8 input cells disabled", padOe, 8'h7E);
    check("R8 input cell feedback", fbOut, 8'h8F);
    cfgAc1 = 8'h00;
  endtask

  task automatic t_opendrain();
    @(negedge sharedClkPin);
    cfgSyn = 1'b1; cfgAc0 = 1'b0; cfgAc1 = 8'h00; cfgXor = 8'h00;
    sumTerm = 8'h55; cfgAc2 = 8'hFF;
    #1;
    check("R9 open-drain flag", padOd, 8'hFF);
    check("R9 open-drain drives low only", padOe, 8'hAA);
    cfgAc2 = 8'h0F;
    #1;
    check("R9 mixed drive flag", padOd, 8'h0F);
    check("R9 mixed drive enables", padOe, 8'hFA);
    cfgAc2 = 8'h00;
    #1;
    check("R9 totem-pole default", padOe, 8'hFF);
  endtask

  initial begin
    #(ClkPeriod * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_reserved();
    t_simple();
    t_complex();
    t_registered();
    t_opendrain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule